// File: doc/BRIEF.md
# Chained-Bank Depth Expansion FIFO

This block joins several equal FIFO banks into one deeper queue behind a single write port and a single read port. Two tokens circle a ring of banks. The write token marks the only bank that may take incoming words. The read token marks the only bank whose storage feeds the output. A bank hands the write token to the next bank in the ring once it has taken as many words as it can hold. It hands the read token on once that many words have left it. Because every bank fills and drains in whole rounds, words come out in the order they went in. The total capacity is the number of banks times the bank depth.

The starting bank is chosen by a per-bank first-load input. The bank whose input is held low during reset receives both tokens. The block has no half-full indication. Its status flags are built by combining the per-bank flags:

- The empty, full, almost-empty and almost-full flags are each asserted only when every bank reports that condition.
- The almost flags are therefore only a rough guide to total occupancy.
- All four flags leave the block through one register stage and describe the occupancy after the same clock edge that changed it.

All banks share one clock. The banks themselves are plain behavioural memories.

Top module: `chainDepthFifo`

## Requirements
- R1: While `rstN` is low, both tokens move to the lowest-indexed bank whose `firstLoadN` bit is 0. After reset, `emptyFlag`=1, `fullFlag`=0, `almostEmpty`=1, `almostFull`=0 and `rdValid`=0.
- R2: A write (`wrEn`=1) is stored in the bank holding the write token if that bank is not full. After DEPTH stored words, the write token moves from bank i to bank (i+1) mod NUM_BANKS. `wrTokOh` bit i is 1 when bank i holds the write token.
- R3: A read (`rdEn`=1) takes a word from the bank holding the read token if that bank is not empty. The word appears on `rdData` with `rdValid`=1 in the next cycle. After DEPTH reads, the read token moves to the next bank in the ring. `rdTokOh` bit i is 1 when bank i holds the read token.
- R4: Across all banks, words are read out in the order they were written. The combined capacity is NUM_BANKS*DEPTH words.
- R5: A write issued while the write-token bank is full is ignored. No word is stored and the write token does not move.
- R6: A read issued while the read-token bank is empty is ignored. `rdValid` stays 0 and the read token does not move.
- R7: `emptyFlag` is 1 exactly when every bank holds no words. It is valid after the same edge that changed occupancy.
- R8: `fullFlag` is 1 exactly when every bank holds DEPTH words. It is valid after the same edge that changed occupancy.
- R9: `almostEmpty` is 1 when every bank holds at most AE_LEVEL words. `almostFull` is 1 when every bank holds at least DEPTH-AF_LEVEL words.
- R10: A read and a write in the same cycle are both carried out when their own banks allow it, including when both tokens are in the same bank.
- R11: `wrTokOh` and `rdTokOh` each have exactly one bit set at all times outside reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all banks |
| rstN | input | 1 | Synchronous reset, active low |
| firstLoadN | input | NUM_BANKS | Per-bank first-load select; the low bit marks the starting bank |
| wrEn | input | 1 | Write request |
| wrData | input | DATA_W | Word to write |
| rdEn | input | 1 | Read request |
| rdData | output | DATA_W | Word read in the previous cycle |
| rdValid | output | 1 | `rdData` carries a new word |
| emptyFlag | output | 1 | Combined empty flag |
| fullFlag | output | 1 | Combined full flag |
| almostEmpty | output | 1 | Combined almost-empty flag |
| almostFull | output | 1 | Combined almost-full flag |
| wrTokOh | output | NUM_BANKS | One-hot position of the write token |
| rdTokOh | output | NUM_BANKS | One-hot position of the read token |

## Verification
The assertions take for granted the following about the inputs:
- Exactly one `firstLoadN` bit is low during reset, and it stays put while reset is held.
- `wrEn` and `rdEn` are never unknown once reset is released.
- Reset lasts long enough for the registered token state to settle.

The stimulus meets these conditions:
- It changes inputs only on the falling edge.
- It picks a single starting bank before each reset and holds reset for several cycles.
- It then mixes full-fill, full-drain and random read/write traffic, so the tokens wrap the ring more than once from two different starting banks.

// File: rtl/chainPkg.sv
package chainPkg;
  // strobes passed from the control to the datapath each cycle
  typedef struct packed {
    logic wrDo;
    logic rdDo;
  } chainStrb_t;
endpackage

// File: rtl/chainCtrl.sv
module chainCtrl
  import chainPkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int DEPTH     = 8,
  parameter int AE_LEVEL  = 1,
  parameter int AF_LEVEL  = 1,
  localparam int BW = $clog2(NUM_BANKS),
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_BANKS-1:0] firstLoadN,
  input  logic                 wrEn,
  input  logic                 rdEn,
  output chainStrb_t           strb,
  output logic [BW-1:0]        wrBank,
  output logic [AW-1:0]        wrAddr,
  output logic [BW-1:0]        rdBank,
  output logic [AW-1:0]        rdAddr,
  output logic                 emptyFlag,
  output logic                 fullFlag,
  output logic                 almostEmpty,
  output logic                 almostFull,
  output logic [NUM_BANKS-1:0] wrTokOh,
  output logic [NUM_BANKS-1:0] rdTokOh
);
  localparam logic [BW-1:0] LAST_BANK = BW'(NUM_BANKS - 1);
  localparam logic [AW-1:0] LAST_POS  = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT  = CW'(DEPTH);
  localparam logic [CW-1:0] AE_CNT    = CW'(AE_LEVEL);
  localparam logic [CW-1:0] AF_CNT    = CW'(DEPTH - AF_LEVEL);

  logic [BW-1:0] wTok, rTok, firstIdx;
  logic [AW-1:0] wPos, rPos;
  logic [CW-1:0] cnt     [NUM_BANKS];
  logic [CW-1:0] cntNext [NUM_BANKS];
  logic          wrOk, rdOk;
  logic          allEmpty, allFull, allLow, allHigh;

  // lowest-indexed bank with first-load low wins
  always_comb begin
    firstIdx = '0;
    for (int i = NUM_BANKS - 1; i >= 0; i--)
      if (!firstLoadN[i]) firstIdx = BW'(i);
  end

  assign wrOk = wrEn && (cnt[wTok] != FULL_CNT);
  assign rdOk = rdEn && (cnt[rTok] != '0);

  assign strb.wrDo = wrOk;
  assign strb.rdDo = rdOk;
  assign wrBank    = wTok;
  assign wrAddr    = wPos;
  assign rdBank    = rTok;
  assign rdAddr    = rPos;

  // token ring: position within the holder bank, hand-over at last slot
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wTok <= firstIdx;
      rTok <= firstIdx;
      wPos <= '0;
      rPos <= '0;
    end else begin
      if (wrOk) begin
        if (wPos == LAST_POS) begin
          wPos <= '0;
          wTok <= (wTok == LAST_BANK) ? '0 : wTok + 1'b1;
        end else begin
          wPos <= wPos + 1'b1;
        end
      end
      if (rdOk) begin
        if (rPos == LAST_POS) begin
          rPos <= '0;
          rTok <= (rTok == LAST_BANK) ? '0 : rTok + 1'b1;
        end else begin
          rPos <= rPos + 1'b1;
        end
      end
    end
  end

  // per-bank occupancy
  for (genvar b = 0; b < NUM_BANKS; b++) begin : gBank
    logic incB, decB;
    assign incB = wrOk && (wTok == BW'(b));
    assign decB = rdOk && (rTok == BW'(b));
    always_comb begin
      cntNext[b] = cnt[b];
      if (incB && !decB) cntNext[b] = cnt[b] + 1'b1;
      if (decB && !incB) cntNext[b] = cnt[b] - 1'b1;
    end
    always_ff @(posedge clk) begin
      if (!rstN) cnt[b] <= '0;
      else       cnt[b] <= cntNext[b];
    end
  end

  // combined flags from next-state occupancy, one register stage
  always_comb begin
    allEmpty = 1'b1;
    allFull  = 1'b1;
    allLow   = 1'b1;
    allHigh  = 1'b1;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (cntNext[i] != '0)      allEmpty = 1'b0;
      if (cntNext[i] != FULL_CNT) allFull = 1'b0;
      if (cntNext[i] > AE_CNT)   allLow   = 1'b0;
      if (cntNext[i] < AF_CNT)   allHigh  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      emptyFlag   <= 1'b1;
      fullFlag    <= 1'b0;
      almostEmpty <= 1'b1;
      almostFull  <= 1'b0;
    end else begin
      emptyFlag   <= allEmpty;
      fullFlag    <= allFull;
      almostEmpty <= allLow;
      almostFull  <= allHigh;
    end
  end

  assign wrTokOh = NUM_BANKS'(1) << wTok;
  assign rdTokOh = NUM_BANKS'(1) << rTok;
endmodule

// File: rtl/chainData.sv
module chainData
  import chainPkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int DEPTH     = 8,
  parameter int DATA_W    = 16,
  localparam int BW = $clog2(NUM_BANKS),
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  chainStrb_t        strb,
  input  logic [BW-1:0]     wrBank,
  input  logic [AW-1:0]     wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [BW-1:0]     rdBank,
  input  logic [AW-1:0]     rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  logic [DATA_W-1:0] bankOut [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gMem
    logic [DATA_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (strb.wrDo && (wrBank == BW'(b))) mem[wrAddr] <= wrData;
    end
    assign bankOut[b] = mem[rdAddr];
  end

  // output mux follows the read-token bank
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strb.rdDo;
      if (strb.rdDo) rdData <= bankOut[rdBank];
    end
  end
endmodule

// File: rtl/chainDepthFifo.sv
module chainDepthFifo
  import chainPkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int DEPTH     = 8,
  parameter int DATA_W    = 16,
  parameter int AE_LEVEL  = 1,
  parameter int AF_LEVEL  = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_BANKS-1:0] firstLoadN,
  input  logic                 wrEn,
  input  logic [DATA_W-1:0]    wrData,
  input  logic                 rdEn,
  output logic [DATA_W-1:0]    rdData,
  output logic                 rdValid,
  output logic                 emptyFlag,
  output logic                 fullFlag,
  output logic                 almostEmpty,
  output logic                 almostFull,
  output logic [NUM_BANKS-1:0] wrTokOh,
  output logic [NUM_BANKS-1:0] rdTokOh
);
  localparam int BW = $clog2(NUM_BANKS);
  localparam int AW = $clog2(DEPTH);

  chainStrb_t    strb;
  logic [BW-1:0] wrBank, rdBank;
  logic [AW-1:0] wrAddr, rdAddr;

  chainCtrl #(
    .NUM_BANKS(NUM_BANKS), .DEPTH(DEPTH),
    .AE_LEVEL(AE_LEVEL), .AF_LEVEL(AF_LEVEL)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .firstLoadN(firstLoadN),
    .wrEn(wrEn), .rdEn(rdEn), .strb(strb),
    .wrBank(wrBank), .wrAddr(wrAddr), .rdBank(rdBank), .rdAddr(rdAddr),
    .emptyFlag(emptyFlag), .fullFlag(fullFlag),
    .almostEmpty(almostEmpty), .almostFull(almostFull),
    .wrTokOh(wrTokOh), .rdTokOh(rdTokOh)
  );

  chainData #(
    .NUM_BANKS(NUM_BANKS), .DEPTH(DEPTH), .DATA_W(DATA_W)
  ) uData (
    .clk(clk), .rstN(rstN), .strb(strb),
    .wrBank(wrBank), .wrAddr(wrAddr), .wrData(wrData),
    .rdBank(rdBank), .rdAddr(rdAddr),
    .rdData(rdData), .rdValid(rdValid)
  );
endmodule

// File: rtl/chainDepthFifoChk.sv
module chainDepthFifoChk #(
  parameter int NUM_BANKS = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 wrEn,
  input logic                 rdEn,
  input logic                 rdValid,
  input logic                 emptyFlag,
  input logic                 fullFlag,
  input logic                 almostEmpty,
  input logic                 almostFull,
  input logic [NUM_BANKS-1:0] wrTokOh,
  input logic [NUM_BANKS-1:0] rdTokOh
);
  // R11
  wr_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(wrTokOh) == 1);
  // R11
  rd_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(rdTokOh) == 1);
  // R2
  wr_tok_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(wrTokOh));
  // R3
  rd_tok_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdTokOh));
  // R5
  full_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    fullFlag && !rdEn |=> fullFlag);
  // R6
  empty_no_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    emptyFlag |=> !rdValid);
  // R7
  empty_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    emptyFlag && !wrEn |=> emptyFlag);
  // R8
  full_not_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    fullFlag |-> (almostFull && !emptyFlag));
  // R9
  empty_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    emptyFlag |-> almostEmpty);
endmodule

bind chainDepthFifo chainDepthFifoChk #(.NUM_BANKS(NUM_BANKS)) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .rdValid(rdValid),
  .emptyFlag(emptyFlag), .fullFlag(fullFlag),
  .almostEmpty(almostEmpty), .almostFull(almostFull),
  .wrTokOh(wrTokOh), .rdTokOh(rdTokOh)
);

// File: tb/tb_chainDepthFifo.sv
module tb_chainDepthFifo;
  localparam int NB  = 4;
  localparam int DEP = 8;
  localparam int DW  = 16;
  localparam int AEL = 1;
  localparam int AFL = 1;

  logic          clk = 1'b0;
  logic          rstN;
  logic [NB-1:0] firstLoadN;
  logic          wrEn, rdEn;
  logic [DW-1:0] wrData;
  logic [DW-1:0] rdData;
  logic          rdValid, emptyFlag, fullFlag, almostEmpty, almostFull;
  logic [NB-1:0] wrTokOh, rdTokOh;

  always #10 clk = ~clk;

  chainDepthFifo #(.NUM_BANKS(NB), .DEPTH(DEP), .DATA_W(DW),
                   .AE_LEVEL(AEL), .AF_LEVEL(AFL)) dut (
    .clk(clk), .rstN(rstN), .firstLoadN(firstLoadN),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rdData(rdData), .rdValid(rdValid),
    .emptyFlag(emptyFlag), .fullFlag(fullFlag),
    .almostEmpty(almostEmpty), .almostFull(almostFull),
    .wrTokOh(wrTokOh), .rdTokOh(rdTokOh)
  );

  int checks = 0;
  int errors = 0;

  // behavioural model
  logic [DW-1:0] dq[$];
  int cnt[NB];
  int wt, rt, wp, rp;
  logic expValid;
  logic [DW-1:0] expData;
  logic [DW-1:0] nextWord = 16'h1000;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic allCnt(input int mode);
    for (int i = 0; i < NB; i++) begin
      if (mode == 0 && cnt[i] != 0)       return 1'b0;
      if (mode == 1 && cnt[i] != DEP)     return 1'b0;
      if (mode == 2 && cnt[i] > AEL)      return 1'b0;
      if (mode == 3 && cnt[i] < DEP - AFL) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic compareAll();
    check("R3 rdValid", 32'(rdValid), 32'(expValid));
    if (expValid) check("R4 rdData order", 32'(rdData), 32'(expData));
    check("R7 emptyFlag", 32'(emptyFlag), 32'(allCnt(0)));
    check("R8 fullFlag", 32'(fullFlag), 32'(allCnt(1)));
    check("R9 almostEmpty", 32'(almostEmpty), 32'(allCnt(2)));
    check("R9 almostFull", 32'(almostFull), 32'(allCnt(3)));
    check("R2 wrTokOh", 32'(wrTokOh), 32'(1) << wt);
    check("R3 rdTokOh", 32'(rdTokOh), 32'(1) << rt);
    check("R11 onehot", 32'($countones(wrTokOh) + $countones(rdTokOh)), 32'd2);
  endtask

  // one cycle: drive at falling edge, update model, compare after the edge
  task automatic step(input logic we, input logic re);
    logic canW, canR;
    @(negedge clk);
    wrEn   = we;
    rdEn   = re;
    wrData = nextWord;
    canW = we && (cnt[wt] < DEP);
    canR = re && (cnt[rt] > 0);
    expValid = canR;
    if (canR) begin
      expData = dq.pop_front();
      cnt[rt]--;
      rp++;
      if (rp == DEP) begin rp = 0; rt = (rt + 1) % NB; end
    end
    if (canW) begin
      dq.push_back(nextWord);
      cnt[wt]++;
      wp++;
      if (wp == DEP) begin wp = 0; wt = (wt + 1) % NB; end
    end
    nextWord = nextWord + 16'd1;
    @(negedge clk);
    wrEn = 1'b0;
    rdEn = 1'b0;
    compareAll();
  endtask

  task automatic doReset(input int first);
    @(negedge clk);
    rstN = 1'b0;
    wrEn = 1'b0;
    rdEn = 1'b0;
    firstLoadN = '1;
    firstLoadN[first] = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    dq.delete();
    for (int i = 0; i < NB; i++) cnt[i] = 0;
    wt = first; rt = first; wp = 0; rp = 0;
    expValid = 1'b0;
    @(negedge clk);
    check("R1 reset empty", 32'(emptyFlag), 32'd1);
    check("R1 reset full", 32'(fullFlag), 32'd0);
    check("R1 reset almostEmpty", 32'(almostEmpty), 32'd1);
    check("R1 reset almostFull", 32'(almostFull), 32'd0);
    check("R1 reset rdValid", 32'(rdValid), 32'd0);
    check("R1 first bank wr", 32'(wrTokOh), 32'(1) << first);
    check("R1 first bank rd", 32'(rdTokOh), 32'(1) << first);
  endtask

  task automatic randomRun(input int n);
    for (int i = 0; i < n; i++)
      step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
  endtask

  initial begin
    rstN = 1'b0; wrEn = 1'b0; rdEn = 1'b0; wrData = '0; firstLoadN = '1;
    doReset(0);
    // R2 / R4: fill to full capacity
    for (int i = 0; i < NB * DEP; i++) step(1'b1, 1'b0);
    check("R8 full after NB*DEP writes", 32'(fullFlag), 32'd1);
    // R5: writes while full are dropped
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
    check("R5 token unmoved when full", 32'(wrTokOh), 32'(1) << 0);
    // R10: read and write in the same cycle while both tokens sit in bank 0
    step(1'b1, 1'b1);
    step(1'b1, 1'b1);
    // drain everything (R3, R4)
    for (int i = 0; i < NB * DEP + 2; i++) step(1'b0, 1'b1);
    check("R7 empty after drain", 32'(emptyFlag), 32'd1);
    // R6: reads while empty are ignored
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1);
    check("R6 no rdValid when empty", 32'(rdValid), 32'd0);
    // R10 mixed traffic
    randomRun(2000);
    // second starting bank (R1)
    doReset(2);
    for (int i = 0; i < NB * DEP - 3; i++) step(1'b1, 1'b0);
    randomRun(1500);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule